// File: doc/BRIEF.md
# XOR Sprite Blitter

This block draws a monochrome sprite, eight pixels wide and one to fifteen rows tall, into a one-bit-per-pixel framebuffer of 64 by 32 pixels. A draw request carries the X and Y origin, the row count and the base address of the sprite bytes. The engine fetches one sprite byte per row over a byte-wide memory read port. It then walks the eight bits of that byte, one pixel per cycle, and inverts each framebuffer pixel whose sprite bit is set through a read-modify-write port. It also reports whether any lit pixel was turned dark. A clear request blanks the whole framebuffer, one pixel per cycle.

Pixels never clip. Each pixel's column wraps modulo 64 and its row wraps modulo 32 on its own, so a sprite near an edge reappears on the opposite side. When a draw or a clear completes, the engine raises a redraw-needed flag. The display side drops that flag with an acknowledge input.

The controller has six states. `ST_IDLE` waits for work. `ST_FETCH` issues the memory read for the current row. `ST_LOAD` captures the returned byte. `ST_PIXEL` handles one sprite bit per cycle. `ST_CLEAR` writes one dark pixel per cycle. `ST_FINISH` emits the done pulse. The transitions are:

- idle→clear on a clear request.
- idle→fetch on a draw request with a non-zero row count.
- idle→finish on a draw request with zero rows.
- fetch→load, always.
- load→pixel, always.
- pixel→fetch after the eighth bit of a row that is not the last.
- pixel→finish after the eighth bit of the last row.
- clear→finish after the last pixel.
- finish→idle, always.

Top module: `sprite_blit_engine`

## Requirements
- R1: After reset, `busy`, `done`, `collision` and `redraw` are all low.
- R2: Sprite row r (0 ≤ r < N) is the byte read from address (base + r) mod 4096. N is the 4-bit `row_count`, and N = 0 draws nothing.
- R3: Bit 7 of a row byte maps to column offset 0, and bit 0 maps to column offset 7.
- R4: A set sprite bit inverts its target pixel. A clear sprite bit leaves its target pixel unchanged.
- R5: The target of bit c in row r is column (X + c) mod 64 and row (Y + r) mod 32. Its framebuffer index is row·64 + column.
- R6: `collision` is cleared when a draw is accepted. It goes high if any set sprite bit of that draw lands on a pixel that was already on. It then holds its value until the next accepted draw.
- R7: A clear request sets all 2048 pixels to off, writing zeros in every cycle of the clear pass. `done` follows 2048 cycles after acceptance.
- R8: A draw of N rows shows `done` 10·N cycles after the accepting edge. `done` lasts exactly one cycle, `busy` is high through the `done` cycle, and `busy` is low on the following cycle.
- R9: A draw or clear request that arrives while `busy` is high is ignored.
- R10: `redraw` rises in the cycle after the `done` of any draw or clear. It stays high until `redraw_ack` is sampled high while no completion is in progress.
- R11: When `clear_req` and `draw_req` are both high in idle, the clear is taken and the draw is dropped.
- R12: The framebuffer write enable and the memory read strobe stay low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| draw_req | input | 1 | Request a sprite draw (taken only in idle) |
| clear_req | input | 1 | Request a full-screen clear (taken only in idle, wins over a draw) |
| org_x | input | 8 | Sprite origin column, wrapped modulo 64 |
| org_y | input | 8 | Sprite origin row, wrapped modulo 32 |
| row_count | input | 4 | Number of sprite rows N |
| base_addr | input | 12 | Address of sprite row 0 |
| redraw_ack | input | 1 | Display acknowledges the redraw flag |
| mem_rd | output | 1 | Memory read strobe; data is returned one cycle later |
| mem_addr | output | 12 | Memory read address |
| mem_rdata | input | 8 | Memory read data |
| fb_addr | output | 11 | Framebuffer pixel index |
| fb_rdata | input | 1 | Current pixel value at `fb_addr` (combinational) |
| fb_we | output | 1 | Framebuffer write enable |
| fb_wdata | output | 1 | New pixel value |
| busy | output | 1 | High from acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | A lit pixel was turned off by the last draw |
| redraw | output | 1 | Framebuffer changed since the last acknowledge |

## Verification
The assertions check, on every cycle, the control-level properties. These are that `done` is a single busy cycle, that the port stays quiet while idle, that the clear pass writes only zeros, and that `redraw` follows `done`. They also check that `collision` drops on acceptance and rises only while busy, and that a simultaneous clear wins. Only the bench's scenarios can show the pixel-level results. These are bit-to-column order, independent wrap on both axes, base-address wrap, XOR and the exact collision value. They also include the cycle count for every row count from 0 to 15 and the effect of requests made while busy. The bench shows these by comparing the whole framebuffer against an arithmetic model after each operation.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int SPRITE_W  = 8;
    localparam int COL_CNT_W = $clog2(SPRITE_W);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_LOAD   = 3'd2,
        ST_PIXEL  = 3'd3,
        ST_CLEAR  = 3'd4,
        ST_FINISH = 3'd5
    } blit_state_e;

endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
    import blit_pkg::*;
#(
    parameter int COORD_W = 8,
    parameter int ADDR_W  = 12,
    parameter int CNT_W   = 4,
    parameter int IDX_W   = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 draw_req,
    input  logic                 clear_req,
    input  logic [COORD_W-1:0]   org_x,
    input  logic [COORD_W-1:0]   org_y,
    input  logic [CNT_W-1:0]     row_count,
    input  logic [ADDR_W-1:0]    base_addr,
    output blit_state_e          state_o,
    output logic [CNT_W-1:0]     row_o,
    output logic [COL_CNT_W-1:0] col_o,
    output logic [IDX_W-1:0]     clr_o,
    output logic [COORD_W-1:0]   x_o,
    output logic [COORD_W-1:0]   y_o,
    output logic [ADDR_W-1:0]    base_o,
    output logic                 draw_begin_o,
    output logic                 load_o,
    output logic                 finish_o
);

    blit_state_e          state_q, state_d;
    logic [CNT_W-1:0]     row_q, rows_q;
    logic [COL_CNT_W-1:0] col_q;
    logic [IDX_W-1:0]     clr_q;
    logic [COORD_W-1:0]   x_q, y_q;
    logic [ADDR_W-1:0]    base_q;

    logic col_last, row_last, clr_last, take_clear, take_draw;

    assign take_clear = (state_q == ST_IDLE) && clear_req;
    assign take_draw  = (state_q == ST_IDLE) && !clear_req && draw_req;
    assign col_last   = (col_q == COL_CNT_W'(SPRITE_W - 1));
    assign row_last   = (row_q == (rows_q - CNT_W'(1)));
    assign clr_last   = (clr_q == {IDX_W{1'b1}});

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clear_req) begin
                    state_d = ST_CLEAR;
                end else if (draw_req) begin
                    state_d = (row_count == '0) ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FETCH:  state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_PIXEL;
            ST_PIXEL: begin
                if (col_last) begin
                    state_d = row_last ? ST_FINISH : ST_FETCH;
                end
            end
            ST_CLEAR: begin
                if (clr_last) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counters and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            rows_q <= '0;
            col_q  <= '0;
            clr_q  <= '0;
            x_q    <= '0;
            y_q    <= '0;
            base_q <= '0;
        end else begin
            if (take_draw) begin
                row_q  <= '0;
                rows_q <= row_count;
                x_q    <= org_x;
                y_q    <= org_y;
                base_q <= base_addr;
            end
            if (take_clear) begin
                clr_q <= '0;
            end
            if (state_q == ST_LOAD) begin
                col_q <= '0;
            end
            if (state_q == ST_PIXEL) begin
                col_q <= col_q + COL_CNT_W'(1);
                if (col_last) begin
                    row_q <= row_q + CNT_W'(1);
                end
            end
            if (state_q == ST_CLEAR) begin
                clr_q <= clr_q + IDX_W'(1);
            end
        end
    end

    assign state_o      = state_q;
    assign row_o        = row_q;
    assign col_o        = col_q;
    assign clr_o        = clr_q;
    assign x_o          = x_q;
    assign y_o          = y_q;
    assign base_o       = base_q;
    assign draw_begin_o = take_draw;
    assign load_o       = (state_q == ST_LOAD);
    assign finish_o     = (state_q == ST_FINISH);

endmodule

// File: rtl/blit_index.sv
module blit_index
    import blit_pkg::*;
#(
    parameter int COORD_W  = 8,
    parameter int CNT_W    = 4,
    parameter int COL_BITS = 6,
    parameter int ROW_BITS = 5,
    localparam int IDX_W   = COL_BITS + ROW_BITS
) (
    input  logic [COORD_W-1:0]   org_x,
    input  logic [COORD_W-1:0]   org_y,
    input  logic [COL_CNT_W-1:0] col_off,
    input  logic [CNT_W-1:0]     row_off,
    output logic [IDX_W-1:0]     idx
);

    logic [COL_BITS-1:0] col_w;
    logic [ROW_BITS-1:0] row_w;

    // power-of-two screen: wrap is a truncation of the full sum
    assign col_w = COL_BITS'(org_x + COORD_W'(col_off));
    assign row_w = ROW_BITS'(org_y + COORD_W'(row_off));
    assign idx   = {row_w, col_w};

endmodule

// File: rtl/blit_row_reg.sv
module blit_row_reg
    import blit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [SPRITE_W-1:0]  din,
    input  logic [COL_CNT_W-1:0] sel,
    output logic                 bit_o
);

    logic [SPRITE_W-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (load) begin
            byte_q <= din;
        end
    end

    // leftmost pixel is the most significant bit
    assign bit_o = byte_q[COL_CNT_W'(SPRITE_W - 1) - sel];

endmodule

// File: rtl/blit_flags.sv
module blit_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic draw_begin,
    input  logic hit,
    input  logic finish,
    input  logic ack,
    output logic collision,
    output logic redraw
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            collision <= 1'b0;
            redraw    <= 1'b0;
        end else begin
            if (draw_begin) begin
                collision <= 1'b0;
            end else if (hit) begin
                collision <= 1'b1;
            end
            if (finish) begin
                redraw <= 1'b1;
            end else if (ack) begin
                redraw <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sprite_blit_engine.sv
module sprite_blit_engine
    import blit_pkg::*;
#(
    parameter int COORD_W  = 8,
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 4,
    parameter int COL_BITS = 6,
    parameter int ROW_BITS = 5,
    localparam int IDX_W   = COL_BITS + ROW_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                draw_req,
    input  logic                clear_req,
    input  logic [COORD_W-1:0]  org_x,
    input  logic [COORD_W-1:0]  org_y,
    input  logic [CNT_W-1:0]    row_count,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic                redraw_ack,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [SPRITE_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]    fb_addr,
    input  logic                fb_rdata,
    output logic                fb_we,
    output logic                fb_wdata,
    output logic                busy,
    output logic                done,
    output logic                collision,
    output logic                redraw
);

    blit_state_e          state_q;
    logic [CNT_W-1:0]     row_q;
    logic [COL_CNT_W-1:0] col_q;
    logic [IDX_W-1:0]     clr_q, pix_idx;
    logic [COORD_W-1:0]   x_q, y_q;
    logic [ADDR_W-1:0]    base_q;
    logic                 draw_begin, load, finish, sprite_bit, hit;

    blit_ctrl #(
        .COORD_W(COORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .draw_req(draw_req), .clear_req(clear_req),
        .org_x(org_x), .org_y(org_y),
        .row_count(row_count), .base_addr(base_addr),
        .state_o(state_q), .row_o(row_q), .col_o(col_q), .clr_o(clr_q),
        .x_o(x_q), .y_o(y_q), .base_o(base_q),
        .draw_begin_o(draw_begin), .load_o(load), .finish_o(finish)
    );

    blit_index #(
        .COORD_W(COORD_W), .CNT_W(CNT_W), .COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS)
    ) u_index (
        .org_x(x_q), .org_y(y_q), .col_off(col_q), .row_off(row_q), .idx(pix_idx)
    );

    blit_row_reg u_row (
        .clk(clk), .rst_n(rst_n), .load(load),
        .din(mem_rdata), .sel(col_q), .bit_o(sprite_bit)
    );

    blit_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .draw_begin(draw_begin), .hit(hit), .finish(finish), .ack(redraw_ack),
        .collision(collision), .redraw(redraw)
    );

    // output decode by state
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = base_q + ADDR_W'(row_q);
        fb_addr  = pix_idx;
        fb_we    = 1'b0;
        fb_wdata = ~fb_rdata;
        hit      = 1'b0;
        unique case (state_q)
            ST_FETCH: mem_rd = 1'b1;
            ST_PIXEL: begin
                fb_we = sprite_bit;
                hit   = sprite_bit && fb_rdata;
            end
            ST_CLEAR: begin
                fb_addr  = clr_q;
                fb_we    = 1'b1;
                fb_wdata = 1'b0;
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = finish;

endmodule

// File: rtl/blit_checker.sv
module blit_checker
    import blit_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        draw_req,
    input logic        clear_req,
    input logic        busy,
    input logic        done,
    input logic        fb_we,
    input logic        fb_wdata,
    input logic        mem_rd,
    input logic        collision,
    input logic        redraw,
    input blit_state_e state_q
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fb_we && !mem_rd));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |-> (fb_we && !fb_wdata));

    // R10
    redraw_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> redraw);

    // R6
    collision_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && draw_req && !clear_req) |=> !collision);

    // R6
    collision_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(collision) |-> $past(busy));

    // R11
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && clear_req) |=> (state_q == ST_CLEAR));

endmodule

bind sprite_blit_engine blit_checker u_chk (
    .clk(clk), .rst_n(rst_n), .draw_req(draw_req), .clear_req(clear_req),
    .busy(busy), .done(done), .fb_we(fb_we), .fb_wdata(fb_wdata),
    .mem_rd(mem_rd), .collision(collision), .redraw(redraw), .state_q(state_q)
);

// File: tb/tb_sprite_blit_engine.sv
module tb_sprite_blit_engine;

    localparam int CLK_PERIOD = 10;
    localparam int FB_PIX = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        draw_req = 1'b0, clear_req = 1'b0, redraw_ack = 1'b0;
    logic [7:0]  org_x = '0, org_y = '0;
    logic [3:0]  row_count = '0;
    logic [11:0] base_addr = '0;
    logic        mem_rd;
    logic [11:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [10:0] fb_addr;
    logic        fb_rdata, fb_we, fb_wdata;
    logic        busy, done, collision, redraw;

    int checks = 0;
    int errors = 0;

    logic [7:0] spr_mem [0:255];
    logic       fb_mem  [0:FB_PIX-1];
    logic       fb_ref  [0:FB_PIX-1];
    logic [7:0] mem_q = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sprite_blit_engine dut (
        .clk(clk), .rst_n(rst_n), .draw_req(draw_req), .clear_req(clear_req),
        .org_x(org_x), .org_y(org_y), .row_count(row_count), .base_addr(base_addr),
        .redraw_ack(redraw_ack), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .fb_addr(fb_addr), .fb_rdata(fb_rdata),
        .fb_we(fb_we), .fb_wdata(fb_wdata), .busy(busy), .done(done),
        .collision(collision), .redraw(redraw)
    );

    always @(posedge clk) if (mem_rd) mem_q <= spr_mem[mem_addr[7:0]];
    assign mem_rdata = mem_q;
    assign fb_rdata  = fb_mem[fb_addr];
    always @(posedge clk) if (fb_we) fb_mem[fb_addr] <= fb_wdata;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cmp_fb(input string req);
        int bad = 0;
        for (int i = 0; i < FB_PIX; i++) if (fb_mem[i] !== fb_ref[i]) bad++;
        check(bad == 0, req, "framebuffer mismatching pixels", bad, 0);
    endtask

    function automatic bit ref_draw(input int x, input int y, input int n, input int base);
        bit col = 0;
        for (int r = 0; r < n; r++) begin
            logic [7:0] b = spr_mem[((base + r) & 12'hFFF) & 8'hFF];
            for (int c = 0; c < 8; c++) begin
                if (b[7-c]) begin
                    int idx = ((y + r) % 32) * 64 + ((x + c) % 64);
                    if (fb_ref[idx]) col = 1;
                    fb_ref[idx] = ~fb_ref[idx];
                end
            end
        end
        return col;
    endfunction

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (done !== 1'b1 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic do_draw(input int x, input int y, input int n, input int base,
                           input bit disturb, input string req);
        bit exp_col;
        int cyc;
        exp_col = ref_draw(x, y, n, base);
        @(negedge clk);
        org_x = 8'(x); org_y = 8'(y); row_count = 4'(n); base_addr = 12'(base);
        draw_req = 1'b1;
        @(negedge clk);
        draw_req = 1'b0;
        cyc = 0;
        if (disturb) begin
            // R9: new requests while busy must be dropped
            draw_req = 1'b1; clear_req = 1'b1;
            org_x = 8'(x + 9); org_y = 8'(y + 4); row_count = 4'd15; base_addr = 12'd7;
            repeat (3) begin @(negedge clk); cyc++; end
            draw_req = 1'b0; clear_req = 1'b0;
        end
        begin
            int rest;
            wait_done(rest);
            cyc += rest;
        end
        check(cyc == 10 * n, "R8", {req, " cycles to done"}, cyc, 10 * n);
        check(collision === exp_col, "R6", {req, " collision"}, int'(collision), int'(exp_col));
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R8", {req, " idle after done"}, int'(busy), 0);
        check(redraw === 1'b1, "R10", {req, " redraw raised"}, int'(redraw), 1);
        cmp_fb(req);
    endtask

    task automatic do_clear(input bit with_draw, input string req);
        int cyc;
        @(negedge clk);
        clear_req = 1'b1;
        draw_req  = with_draw;
        org_x = 8'd3; org_y = 8'd3; row_count = 4'd4; base_addr = 12'd0;
        @(negedge clk);
        clear_req = 1'b0; draw_req = 1'b0;
        wait_done(cyc);
        for (int i = 0; i < FB_PIX; i++) fb_ref[i] = 1'b0;
        check(cyc == FB_PIX, req, "clear cycles to done", cyc, FB_PIX);
        @(negedge clk);
        check(redraw === 1'b1, "R10", "redraw after clear", int'(redraw), 1);
        cmp_fb(req);
    endtask

    task automatic ack_redraw();
        @(negedge clk); redraw_ack = 1'b1;
        @(negedge clk); redraw_ack = 1'b0;
        check(redraw === 1'b0, "R10", "redraw dropped by ack", int'(redraw), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) spr_mem[i] = 8'((i * 73 + 29) ^ (i >> 2));
        for (int i = 0; i < FB_PIX; i++) begin
            fb_mem[i] = (i % 3 == 0);
            fb_ref[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1
        check(busy === 0 && done === 0, "R1", "busy/done in reset", int'(busy), 0);
        check(collision === 0 && redraw === 0, "R1", "flags in reset", int'(collision), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 0, "R1", "idle after reset release", int'(busy), 0);

        // R7 clear of a patterned screen
        do_clear(1'b0, "R7");
        ack_redraw();

        // R2 R4 R5 R6 R8 sweep of row counts, origins with wrap, repeated to erase
        for (int n = 0; n <= 15; n++) begin
            int x = (n * 17 + 50) % 256;
            int y = (n * 5 + 20) % 256;
            do_draw(x, y, n, n * 9, 1'b0, "R5 sweep");
            do_draw(x, y, n, n * 9, 1'b0, "R4 erase");
            ack_redraw();
        end
        for (int x = 56; x < 256; x += 29) do_draw(x, x + 3, 6, x, 1'b0, "R5 xwrap");

        // R3 bit order
        do_clear(1'b0, "R7");
        spr_mem[200] = 8'h80;
        do_draw(5, 3, 1, 200, 1'b0, "R3");
        check(fb_mem[3*64+5] === 1'b1, "R3", "msb at column offset 0", int'(fb_mem[3*64+5]), 1);
        check(fb_mem[3*64+6] === 1'b0, "R3", "next column dark", int'(fb_mem[3*64+6]), 0);

        // R2 base address wrap, R5 wrap on both axes
        spr_mem[8'hFE] = 8'hC3; spr_mem[8'hFF] = 8'h3C; spr_mem[8'h00] = 8'hA5;
        do_draw(62, 31, 3, 12'hFFE, 1'b0, "R2 base wrap");

        // R6 overlap cases
        do_clear(1'b0, "R7");
        spr_mem[10] = 8'h0F; spr_mem[11] = 8'hF0; spr_mem[12] = 8'h18;
        do_draw(0, 0, 1, 10, 1'b0, "R6 first");
        do_draw(0, 0, 1, 11, 1'b0, "R6 disjoint");
        do_draw(0, 0, 1, 12, 1'b0, "R6 overlap");
        repeat (5) @(negedge clk);
        check(collision === 1'b1, "R6", "collision held while idle", int'(collision), 1);
        do_draw(20, 10, 1, 12, 1'b0, "R6 cleared by new draw");

        // R9 requests while busy
        do_draw(30, 15, 5, 40, 1'b1, "R9");

        // R11 clear wins over simultaneous draw
        do_clear(1'b1, "R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule